// File: doc/BRIEF.md
# Partitioned 128-bit Lane Adder

This block adds two 128-bit vector operands lane by lane. At run time a two-bit size code splits the datapath into sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit lanes. Every lane performs the same addition in the same cycle, and no carry passes from one lane into the next.

A signedness select sets how each lane is read, either as a two's-complement integer or as an unsigned integer. The lane's overflow flag follows that choice. In wrapping mode each lane result is reduced modulo 2^width. In saturating mode a lane that overflows is clamped to its limit. Results and flags are captured in one output register stage that loads only when the valid strobe is high.

Top module: `simd_add128`

## Requirements
- R1: `lane_sz_i` selects the lane width: 00 = 8 bits (16 lanes), 01 = 16 bits (8 lanes), 10 = 32 bits (4 lanes), 11 = 64 bits (2 lanes). Lane n occupies bits [n*w +: w]. The carry out of a lane's top bit never reaches the lane above it.
- R2: When `sat_i` = 0, each lane result equals (a + b) mod 2^w, whatever `signed_i` is.
- R3: When `sat_i` = 1 and `signed_i` = 0, a lane whose unsigned sum exceeds 2^w - 1 outputs all ones.
- R4: When `sat_i` = 1 and `signed_i` = 1, a lane whose signed sum overflows outputs 2^(w-1) - 1 if both operands are non-negative. It outputs -2^(w-1) if both are negative.
- R5: With `signed_i` = 0, a lane's overflow flag is the carry out of the lane's top bit.
- R6: With `signed_i` = 1, a lane's overflow flag is set when both operands have the same sign and the wrapped result has the other sign.
- R7: `ovf_o` has one bit per byte. A lane's flag sits at bit n*(w/8), which is the lane's lowest byte. All other bits of that lane's group read 0. Flags are reported in both wrapping and saturating mode.
- R8: `sum_o` and `ovf_o` load on the rising clock edge where `valid_i` = 1, which gives one cycle of latency. When `valid_i` = 0 they hold their previous value.
- R9: While `rst_ni` is low, `sum_o` and `ovf_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load strobe for the output register |
| lane_sz_i | input | 2 | Lane width code |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| sat_i | input | 1 | 1 = saturating, 0 = wrapping |
| a_i | input | 128 | First operand |
| b_i | input | 128 | Second operand |
| sum_o | output | 128 | Registered lane results |
| ovf_o | output | 16 | Registered per-lane overflow flags |

## Verification
A carry kill at the wrong byte boundary appears one cycle after the strobe. It shows as a single-unit error in the low byte of the lane above, so operands of all-ones plus ones are driven at every lane size. A fill value or flag taken from the wrong byte of its lane shows in that same cycle, as a wrong clamp or a flag at a bit position that should be zero. The scoreboard compares every strobed result against a lane-level model. Separate checks confirm that the register holds when the strobe is low.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } lane_sz_e;

  function automatic int unsigned lane_bytes(input lane_sz_e sz);
    return 32'd1 << int'(sz);
  endfunction

  // byte k opens a lane
  function automatic logic lane_first(input int unsigned k, input lane_sz_e sz);
    return (k & (lane_bytes(sz) - 32'd1)) == 32'd0;
  endfunction

  // index of the most significant byte of the lane holding byte k
  function automatic int unsigned lane_top(input int unsigned k, input lane_sz_e sz);
    return k | (lane_bytes(sz) - 32'd1);
  endfunction
endpackage

// File: rtl/simd_byte_chain.sv
module simd_byte_chain
  import simd_add_pkg::*;
#(
  parameter  int unsigned NB = 16,
  localparam int unsigned W  = NB * BYTE_W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  lane_sz_e      sz_i,
  output logic [W-1:0]  sum_o,
  output logic [NB-1:0] cout_o,
  output logic [NB-1:0] sovf_o
);
  always_comb begin
    logic            cin;
    logic [BYTE_W:0] t;
    sum_o  = '0;
    cout_o = '0;
    sovf_o = '0;
    cin    = 1'b0;
    t      = '0;
    for (int unsigned k = 0; k < NB; k++) begin
      // carry kill at every lane boundary
      if (lane_first(k, sz_i)) cin = 1'b0;
      t = {1'b0, a_i[k*BYTE_W +: BYTE_W]} + {1'b0, b_i[k*BYTE_W +: BYTE_W]}
          + {{BYTE_W{1'b0}}, cin};
      sum_o[k*BYTE_W +: BYTE_W] = t[BYTE_W-1:0];
      cout_o[k] = t[BYTE_W];
      sovf_o[k] = (a_i[k*BYTE_W+BYTE_W-1] == b_i[k*BYTE_W+BYTE_W-1]) &&
                  (t[BYTE_W-1] != a_i[k*BYTE_W+BYTE_W-1]);
      cin = t[BYTE_W];
    end
  end
endmodule

// File: rtl/simd_sat_sel.sv
module simd_sat_sel
  import simd_add_pkg::*;
#(
  parameter  int unsigned NB = 16,
  localparam int unsigned W  = NB * BYTE_W,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  raw_i,
  input  logic [NB-1:0] cout_i,
  input  logic [NB-1:0] sovf_i,
  input  lane_sz_e      sz_i,
  input  logic          signed_i,
  input  logic          sat_i,
  output logic [W-1:0]  res_o,
  output logic [NB-1:0] ovf_o
);
  logic [NB-1:0] a_msb;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [IW-1:0]     top;
    logic              lane_ovf;
    logic              neg;
    logic [BYTE_W-1:0] fill;
    logic [BYTE_W-1:0] res_b;

    assign a_msb[k] = a_i[k*BYTE_W+BYTE_W-1];

    always_comb begin
      top      = IW'(lane_top(k, sz_i));
      lane_ovf = signed_i ? sovf_i[top] : cout_i[top];
      neg      = a_msb[top];
      if (!signed_i)              fill = '1;
      else if (int'(top) == k)    fill = neg ? {1'b1, {(BYTE_W-1){1'b0}}} : {1'b0, {(BYTE_W-1){1'b1}}};
      else                        fill = neg ? '0 : '1;
      res_b = (sat_i && lane_ovf) ? fill : raw_i[k*BYTE_W +: BYTE_W];
    end

    assign res_o[k*BYTE_W +: BYTE_W] = res_b;
    // flag lives at the lowest byte of its lane
    assign ovf_o[k] = lane_first(k, sz_i) ? lane_ovf : 1'b0;
  end
endmodule

// File: rtl/simd_add128.sv
module simd_add128
  import simd_add_pkg::*;
#(
  parameter  int unsigned DATA_W = 128,
  localparam int unsigned NB     = DATA_W / BYTE_W,
  localparam int unsigned WIDE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        lane_sz_i,
  input  logic              signed_i,
  input  logic              sat_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NB-1:0]     ovf_o
);
  lane_sz_e          sz;
  logic [DATA_W-1:0] raw;
  logic [NB-1:0]     cout;
  logic [NB-1:0]     sovf;
  logic [DATA_W-1:0] res_d;
  logic [NB-1:0]     ovf_d;

  assign sz = lane_sz_e'(lane_sz_i);

  simd_byte_chain #(.NB(NB)) u_chain (
    .a_i    (a_i),
    .b_i    (b_i),
    .sz_i   (sz),
    .sum_o  (raw),
    .cout_o (cout),
    .sovf_o (sovf)
  );

  simd_sat_sel #(.NB(NB)) u_sat (
    .a_i      (a_i),
    .raw_i    (raw),
    .cout_i   (cout),
    .sovf_i   (sovf),
    .sz_i     (sz),
    .signed_i (signed_i),
    .sat_i    (sat_i),
    .res_o    (res_d),
    .ovf_o    (ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      ovf_o <= '0;
    end else if (valid_i) begin
      sum_o <= res_d;
      ovf_o <= ovf_d;
    end
  end

  // lane-start mask, for checking only
  logic [NB-1:0] start_mask;
  always_comb begin
    start_mask = '0;
    for (int unsigned k = 0; k < NB; k = k + lane_bytes(sz)) start_mask[k] = 1'b1;
  end

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(sum_o) && $stable(ovf_o)));

  // R2
  wrap_byte0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sat_i) |=> (sum_o[BYTE_W-1:0] == $past(a_i[BYTE_W-1:0] + b_i[BYTE_W-1:0])));

  // R1
  wide_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sat_i && lane_sz_i == 2'b11)
      |=> (sum_o[WIDE_W-1:0] == $past(a_i[WIDE_W-1:0] + b_i[WIDE_W-1:0])));

  // R7
  ovf_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((ovf_o & ~$past(start_mask)) == '0));

  // R3
  usat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sat_i && !signed_i) |=> (!ovf_o[0] || sum_o[BYTE_W-1:0] == '1));
endmodule

// File: tb/tb_simd_add128.sv
module tb_simd_add128;
  localparam int unsigned DW = 128;
  localparam int unsigned NB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [1:0]    lsz = 2'b00;
  logic          sgn = 1'b0;
  logic          sat = 1'b0;
  logic [DW-1:0] a = '0;
  logic [DW-1:0] b = '0;
  logic [DW-1:0] sum;
  logic [NB-1:0] ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [DW-1:0] sum;
    logic [NB-1:0] ovf;
    string         stag;
    string         otag;
  } exp_t;
  exp_t q[$];
  exp_t last;

  always #10 clk = ~clk;  // 50 MHz

  simd_add128 dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .lane_sz_i(lsz),
    .signed_i(sgn), .sat_i(sat), .a_i(a), .b_i(b), .sum_o(sum), .ovf_o(ovf)
  );

  function automatic exp_t model(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                 input logic [1:0] sz, input logic s, input logic st);
    exp_t e;
    int w = 8 << sz;
    int n = NB >> sz;
    e.sum = '0; e.ovf = '0;
    for (int l = 0; l < n; l++) begin
      logic [63:0] xa, ya, r, mn;
      logic [64:0] su;
      logic of, xs, ys;
      xa = '0; ya = '0;
      for (int j = 0; j < w; j++) begin xa[j] = x[l*w+j]; ya[j] = y[l*w+j]; end
      su = {1'b0, xa} + {1'b0, ya};
      xs = xa[w-1]; ys = ya[w-1];
      r  = su[63:0];
      of = s ? ((xs == ys) && (r[w-1] != xs)) : su[w];
      if (st && of) begin
        mn = 64'd1 << (w-1);
        if (!s) r = '1;
        else    r = xs ? mn : mn - 64'd1;
      end
      for (int j = 0; j < w; j++) e.sum[l*w+j] = r[j];
      e.ovf[l*(w/8)] = of;
    end
    e.stag = st ? (s ? "R4" : "R3") : (s ? "R6" : "R2");
    e.otag = s ? "R6" : "R5";
    return e;
  endfunction

  task automatic send(input logic [DW-1:0] x, input logic [DW-1:0] y,
                      input logic [1:0] sz, input logic s, input logic st, input string tag);
    exp_t e;
    @(negedge clk);
    a = x; b = y; lsz = sz; sgn = s; sat = st; valid = 1'b1;
    e = model(x, y, sz, s, st);
    if (tag != "") e.stag = tag;
    q.push_back(e);
    last = e;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0;
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    if (rst_n && valid) begin
      exp_t e;
      #5;
      if (q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R8: output loaded with no expected item");
      end else begin
        e = q.pop_front();
        n_tests++;
        if (sum !== e.sum) begin
          n_fail++;
          $display("FAIL %s: sum %h expected %h", e.stag, sum, e.sum);
        end
        n_tests++;
        // R7 group layout checked with the flag value
        if (ovf !== e.ovf) begin
          n_fail++;
          $display("FAIL %s/R7: ovf %h expected %h", e.otag, ovf, e.ovf);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] ones, ox01, ox7f, ox80;
    ones = '1;
    ox01 = {NB{8'h01}};
    ox7f = {NB{8'h7F}};
    ox80 = {NB{8'h80}};

    // R9 reset state
    a = ones; b = ones; valid = 1'b1;
    #35;
    n_tests++;
    if (sum !== '0 || ovf !== '0) begin
      n_fail++;
      $display("FAIL R9: sum %h ovf %h expected 0 0", sum, ovf);
    end
    @(negedge clk); valid = 1'b0; rst_n = 1'b1;

    // R1 carry kill at every lane size, wrapping
    for (int sz = 0; sz < 4; sz++) send(ones, ox01, 2'(sz), 1'b0, 1'b0, "R1");
    send(128'h0, 128'h0, 2'b00, 1'b0, 1'b0, "R2");
    // R3 unsigned clamp
    for (int sz = 0; sz < 4; sz++) send(ones, ox01, 2'(sz), 1'b0, 1'b1, "R3");
    // R4 signed clamp, positive and negative
    for (int sz = 0; sz < 4; sz++) begin
      send(ox7f | {NB/2{16'hFF00}}, ox01 | {NB/2{16'h7F00}}, 2'(sz), 1'b1, 1'b1, "R4");
      send(ox80, ox80, 2'(sz), 1'b1, 1'b1, "R4");
      send(ox80, ones, 2'(sz), 1'b1, 1'b0, "R6");
    end
    // R6 no false flag on mixed signs
    send(ox7f, ox80, 2'b00, 1'b1, 1'b0, "R6");
    // R5 single carry into lane boundary, 64-bit
    send({64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'h1}, 2'b11, 1'b0, 1'b0, "R1");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [DW-1:0] x, y;
      x = {$urandom, $urandom, $urandom, $urandom};
      y = {$urandom, $urandom, $urandom, $urandom};
      if (i % 3 == 0) y = ~x ^ {$urandom, $urandom, $urandom, $urandom} & {NB{8'h01}};
      send(x, y, 2'($urandom), 1'($urandom), 1'($urandom), "");
    end
    idle();
    repeat (2) @(negedge clk);

    // R8 hold with strobe low and changing operands
    send(ones, ox01, 2'b01, 1'b0, 1'b1, "R8");
    @(negedge clk);
    valid = 1'b0; a = 128'h1234; b = 128'h5678; lsz = 2'b00; sat = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5;
      n_tests++;
      if (sum !== last.sum || ovf !== last.ovf) begin
        n_fail++;
        $display("FAIL R8: sum %h ovf %h expected %h %h", sum, ovf, last.sum, last.ovf);
      end
      @(negedge clk);
      a = {$urandom, $urandom, $urandom, $urandom};
    end

    repeat (3) @(negedge clk);
    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R8: %0d results missing expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule